// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block produces the timing for a successive-approximation analog-to-digital conversion: a sample-and-hold window, one strobe per result bit and an end-of-conversion pulse. Everything runs on the system clock. A programmable prescaler makes a conversion-clock enable from it. The comparator and the internal DAC are outside the block. They consume the strobes it issues.

Software sets the block up through a simple write port. Each write carries the whole register: prescaler select, sampling-length mode, trigger mode, an enable bit and a start bit. The block checks every write against a set of locking rules. A write that breaks a rule is dropped as a whole and raises a sticky error flag. A conversion starts in one of two ways. In software mode, an accepted write that sets the start bit launches it. In the hardware modes, a trigger pulse launches it while the start bit is held. One hardware mode adds a two-clock stabilization wait before sampling.

Top module: `adc_seq_timer`

## Requirements
- R1: The prescaler select field `wr_div_sel` picks the conversion-clock length in system clocks: 0 gives 32, 1 gives 16, 2 gives 8, 3 gives 6, 4 gives 5, 5 gives 4 and 6 gives 2. A write with select 7 is rejected.
- R2: With `wr_short_smp`=0, a conversion lasts 19 conversion clocks. The first 7 of them (after any wait) form the sampling window.
- R3: With `wr_short_smp`=1, a conversion lasts 17 conversion clocks and samples for 5 of them.
- R4: `wr_trig_mode` selects the trigger mode: 0 is software, 1 is hardware without wait, and 2 is hardware with a 2-conversion-clock wait before sampling, which adds to the total length. A write with mode 3 is rejected.
- R5: After sampling, `bit_strobe` pulses 10 times for one system clock each, in the last system cycle of each of the 10 following conversion clocks. Two overhead clocks follow. `eoc` is high for exactly the last system cycle of the conversion. Counted from the launching clock edge, `eoc` is seen in cycle T*N, where T is the total number of conversion clocks and N the prescaler ratio.
- R6: In software mode, the clock edge that accepts a write raising the start bit launches the conversion. The start bit clears by itself at the end of the conversion.
- R7: While the enable or start bit is 1, a write that changes the select, speed or trigger-mode fields is rejected. A write that leaves those fields unchanged is accepted.
- R8: A write with start=1 and enable=0 is rejected.
- R9: A write that raises enable and start together, with enable previously 0, is rejected.
- R10: A rejected write changes no register. It sets `cfg_err`, which stays 1 until reset while legal writes are still accepted.
- R11: An accepted write that clears the start bit aborts a running conversion. From the next cycle on, `sample_hold`, `bit_strobe` and `eoc` stay low and no end-of-conversion follows.
- R12: In a hardware mode, a conversion launches on the clock edge where `hw_trig` is high, the sequencer is idle and the start bit is 1. Triggers while busy or while the start bit is 0 are ignored.
- R13: After reset, all outputs are 0 and the readback shows select 0, speed 0, software mode, enable 0 and start 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| wr_div_sel | input | 3 | Prescaler select written |
| wr_short_smp | input | 1 | Speed mode written (1 = short sampling) |
| wr_trig_mode | input | 2 | Trigger mode written |
| wr_enable | input | 1 | Enable bit written |
| wr_start | input | 1 | Start bit written |
| hw_trig | input | 1 | Hardware conversion trigger |
| sample_hold | output | 1 | High during the sampling window |
| bit_strobe | output | 1 | One-cycle pulse per result bit |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| cfg_err | output | 1 | Sticky rejected-write flag |
| rd_div_sel | output | 3 | Current prescaler select |
| rd_short_smp | output | 1 | Current speed mode |
| rd_trig_mode | output | 2 | Current trigger mode |
| rd_enable | output | 1 | Current enable bit |
| rd_start | output | 1 | Current start bit |

## Verification
A wrong prescaler count or conversion-clock index changes the conversion length at once. The bench counts the system cycles to `eoc`, the length of `sample_hold` and the number of strobes for every ratio and mode, so such an error appears within the same conversion. A wrong lock decision appears on the readback outputs and on `cfg_err` in the cycle after the offending write. A missing abort or self-clear appears either as an unexpected `eoc` within one conversion length or as a stale `rd_start` one cycle after `eoc`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SEL_W      = 3;
    localparam int MODE_W     = 2;
    localparam int CIDX_W     = 5;
    localparam int PCNT_W     = 5;
    localparam int STD_SAMP   = 7;
    localparam int SHORT_SAMP = 5;
    localparam int RES_BITS   = 10;
    localparam int OVH_CLKS   = 2;
    localparam int WAIT_CLKS  = 2;

    typedef enum logic [MODE_W-1:0] {
        TRG_SW      = 2'd0,
        TRG_HW      = 2'd1,
        TRG_HW_WAIT = 2'd2,
        TRG_BAD     = 2'd3
    } trig_mode_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] div_sel;
        logic             short_smp;
        trig_mode_e       mode;
    } adc_cfg_t;

    typedef struct packed {
        logic [CIDX_W-1:0] wait_end;
        logic [CIDX_W-1:0] samp_end;
        logic [CIDX_W-1:0] bits_end;
        logic [CIDX_W-1:0] last;
    } phase_lim_t;

    // terminal prescaler count (ratio minus one) for each select code
    function automatic logic [PCNT_W-1:0] div_last(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return PCNT_W'(31);
            3'd1:    return PCNT_W'(15);
            3'd2:    return PCNT_W'(7);
            3'd3:    return PCNT_W'(5);
            3'd4:    return PCNT_W'(4);
            3'd5:    return PCNT_W'(3);
            3'd6:    return PCNT_W'(1);
            default: return PCNT_W'(31);
        endcase
    endfunction

    function automatic logic div_legal(input logic [SEL_W-1:0] sel);
        return sel != 3'd7;
    endfunction

    // phase boundaries in conversion clocks for a configuration
    function automatic phase_lim_t phase_limits(input adc_cfg_t c);
        int w;
        int s;
        phase_lim_t l;
        w = (c.mode == TRG_HW_WAIT) ? WAIT_CLKS : 0;
        s = c.short_smp ? SHORT_SAMP : STD_SAMP;
        l.wait_end = CIDX_W'(w);
        l.samp_end = CIDX_W'(w + s);
        l.bits_end = CIDX_W'(w + s + RES_BITS);
        l.last     = CIDX_W'(w + s + RES_BITS + OVH_CLKS - 1);
        return l;
    endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     reg_wr,
    input  adc_cfg_t wr_cfg,
    input  logic     wr_enable,
    input  logic     wr_start,
    input  logic     conv_done,
    output adc_cfg_t cfg_q,
    output logic     en_q,
    output logic     start_q,
    output logic     err_q,
    output logic     sw_launch
);

    logic bad_start_only;
    logic bad_joint_rise;
    logic bad_lock;
    logic bad_code;
    logic reject;
    logic accept;

    always_comb begin
        bad_start_only = wr_start && !wr_enable;
        bad_joint_rise = !en_q && wr_enable && wr_start;
        bad_lock       = (en_q || start_q) && (wr_cfg != cfg_q);
        bad_code       = !div_legal(wr_cfg.div_sel) || (wr_cfg.mode == TRG_BAD);
        reject         = reg_wr && (bad_start_only || bad_joint_rise || bad_lock || bad_code);
        accept         = reg_wr && !reject;
        sw_launch      = accept && wr_start && !start_q && (wr_cfg.mode == TRG_SW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{div_sel: '0, short_smp: 1'b0, mode: TRG_SW};
            en_q    <= 1'b0;
            start_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                cfg_q   <= wr_cfg;
                en_q    <= wr_enable;
                start_q <= wr_start;
            end else if (conv_done && cfg_q.mode == TRG_SW) begin
                start_q <= 1'b0;
            end
            if (reject) begin
                err_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_seq_presc.sv
module adc_seq_presc
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              running,
    input  logic              restart,
    input  logic [PCNT_W-1:0] term,
    output logic              tick
);

    logic [PCNT_W-1:0] cnt;

    assign tick = running && (cnt == term);

    always_ff @(posedge clk) begin
        if (rst || !running || restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_q,
    input  adc_cfg_t cfg,
    input  logic     sw_launch,
    input  logic     hw_trig,
    input  logic     tick,
    output logic     running,
    output logic     restart,
    output logic     sample_hold,
    output logic     bit_strobe,
    output logic     eoc
);

    seq_state_e        state;
    logic [CIDX_W-1:0] cidx;
    phase_lim_t        lim;
    logic              hw_launch;
    logic              live;
    logic              at_last;

    always_comb begin
        lim         = phase_limits(cfg);
        hw_launch   = (state == SEQ_IDLE) && start_q && (cfg.mode != TRG_SW) && hw_trig;
        restart     = sw_launch || hw_launch;
        running     = (state == SEQ_RUN);
        live        = running && start_q;
        at_last     = (cidx == lim.last);
        sample_hold = live && (cidx >= lim.wait_end) && (cidx < lim.samp_end);
        bit_strobe  = live && tick && (cidx >= lim.samp_end) && (cidx < lim.bits_end);
        eoc         = live && tick && at_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cidx  <= '0;
        end else if (sw_launch) begin
            state <= SEQ_RUN;
            cidx  <= '0;
        end else if (running && !start_q) begin
            state <= SEQ_IDLE;
            cidx  <= '0;
        end else if (hw_launch) begin
            state <= SEQ_RUN;
            cidx  <= '0;
        end else if (running && tick) begin
            if (at_last) begin
                state <= SEQ_IDLE;
                cidx  <= '0;
            end else begin
                cidx <= cidx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  wr_div_sel,
    input  logic              wr_short_smp,
    input  logic [MODE_W-1:0] wr_trig_mode,
    input  logic              wr_enable,
    input  logic              wr_start,
    input  logic              hw_trig,
    output logic              sample_hold,
    output logic              bit_strobe,
    output logic              eoc,
    output logic              cfg_err,
    output logic [SEL_W-1:0]  rd_div_sel,
    output logic              rd_short_smp,
    output logic [MODE_W-1:0] rd_trig_mode,
    output logic              rd_enable,
    output logic              rd_start
);

    adc_cfg_t wr_cfg;
    adc_cfg_t cfg_q;
    logic     start_q;
    logic     sw_launch;
    logic     running;
    logic     restart;
    logic     tick;

    always_comb begin
        wr_cfg.div_sel   = wr_div_sel;
        wr_cfg.short_smp = wr_short_smp;
        wr_cfg.mode      = trig_mode_e'(wr_trig_mode);
    end

    adc_seq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .wr_cfg    (wr_cfg),
        .wr_enable (wr_enable),
        .wr_start  (wr_start),
        .conv_done (eoc),
        .cfg_q     (cfg_q),
        .en_q      (rd_enable),
        .start_q   (start_q),
        .err_q     (cfg_err),
        .sw_launch (sw_launch)
    );

    adc_seq_presc u_presc (
        .clk     (clk),
        .rst     (rst),
        .running (running),
        .restart (restart),
        .term    (div_last(cfg_q.div_sel)),
        .tick    (tick)
    );

    adc_seq_core u_core (
        .clk         (clk),
        .rst         (rst),
        .start_q     (start_q),
        .cfg         (cfg_q),
        .sw_launch   (sw_launch),
        .hw_trig     (hw_trig),
        .tick        (tick),
        .running     (running),
        .restart     (restart),
        .sample_hold (sample_hold),
        .bit_strobe  (bit_strobe),
        .eoc         (eoc)
    );

    assign rd_div_sel   = cfg_q.div_sel;
    assign rd_short_smp = cfg_q.short_smp;
    assign rd_trig_mode = cfg_q.mode;
    assign rd_start     = start_q;

endmodule

// File: rtl/adc_seq_timer_chk.sv
module adc_seq_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       sample_hold,
    input logic       bit_strobe,
    input logic       eoc,
    input logic       cfg_err,
    input logic [2:0] rd_div_sel,
    input logic       rd_short_smp,
    input logic [1:0] rd_trig_mode,
    input logic       rd_enable,
    input logic       rd_start
);

    logic [3:0] strb_cnt;

    always_ff @(posedge clk) begin
        if (rst || eoc || !rd_start) begin
            strb_cnt <= '0;
        end else if (bit_strobe) begin
            strb_cnt <= strb_cnt + 1'b1;
        end
    end

    // R1: prohibited select never reaches the register
    p_div_legal_r1: assert property (@(posedge clk) disable iff (rst)
        rd_div_sel != 3'd7);

    // R4: prohibited trigger mode never reaches the register
    p_mode_legal_r4: assert property (@(posedge clk) disable iff (rst)
        rd_trig_mode != 2'd3);

    // R5: strobes never overlap sampling
    p_strobe_outside_sample_r5: assert property (@(posedge clk) disable iff (rst)
        !(sample_hold && bit_strobe));

    // R5: end of conversion lasts one cycle
    p_eoc_single_r5: assert property (@(posedge clk) disable iff (rst)
        eoc |=> !eoc);

    // R5: ten strobes precede every end of conversion
    p_ten_strobes_r5: assert property (@(posedge clk) disable iff (rst)
        eoc |-> strb_cnt == 4'd10);

    // R7: configuration frozen while enabled or started
    p_cfg_locked_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_enable || rd_start) |=> ($stable(rd_div_sel) && $stable(rd_short_smp) && $stable(rd_trig_mode)));

    // R8: start never held without enable
    p_start_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
        rd_start |-> rd_enable);

    // R10: error flag is sticky
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    // R11: with start clear, conversion outputs stay quiet
    p_abort_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_start |-> (!sample_hold && !bit_strobe && !eoc));

endmodule

bind adc_seq_timer adc_seq_timer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_hold  (sample_hold),
    .bit_strobe   (bit_strobe),
    .eoc          (eoc),
    .cfg_err      (cfg_err),
    .rd_div_sel   (rd_div_sel),
    .rd_short_smp (rd_short_smp),
    .rd_trig_mode (rd_trig_mode),
    .rd_enable    (rd_enable),
    .rd_start     (rd_start)
);

// File: tb/adc_seq_timer_tb.sv
`timescale 1ns/1ps
module adc_seq_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] wr_div_sel = '0;
    logic       wr_short_smp = 1'b0;
    logic [1:0] wr_trig_mode = '0;
    logic       wr_enable = 1'b0;
    logic       wr_start = 1'b0;
    logic       hw_trig = 1'b0;
    logic       sample_hold;
    logic       bit_strobe;
    logic       eoc;
    logic       cfg_err;
    logic [2:0] rd_div_sel;
    logic       rd_short_smp;
    logic [1:0] rd_trig_mode;
    logic       rd_enable;
    logic       rd_start;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_seq_timer u_dut (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .wr_div_sel   (wr_div_sel),
        .wr_short_smp (wr_short_smp),
        .wr_trig_mode (wr_trig_mode),
        .wr_enable    (wr_enable),
        .wr_start     (wr_start),
        .hw_trig      (hw_trig),
        .sample_hold  (sample_hold),
        .bit_strobe   (bit_strobe),
        .eoc          (eoc),
        .cfg_err      (cfg_err),
        .rd_div_sel   (rd_div_sel),
        .rd_short_smp (rd_short_smp),
        .rd_trig_mode (rd_trig_mode),
        .rd_enable    (rd_enable),
        .rd_start     (rd_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input int div, input int shrt, input int mode, input int en, input int st);
        wr_div_sel   = 3'(div);
        wr_short_smp = 1'(shrt);
        wr_trig_mode = 2'(mode);
        wr_enable    = 1'(en);
        wr_start     = 1'(st);
        reg_wr       = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic trig_pulse();
        hw_trig = 1'b1;
        @(posedge clk);
        #1 hw_trig = 1'b0;
    endtask

    task automatic measure(input string req, input int tot, input int wt, input int smp);
        int n = 0;
        int first = -1;
        int sh = 0;
        int bs = 0;
        bit seen = 1'b0;
        while (!seen && n < tot + 40) begin
            @(negedge clk);
            n++;
            if (sample_hold) begin
                sh++;
                if (first < 0) first = n - 1;
            end
            if (bit_strobe) bs++;
            if (eoc) seen = 1'b1;
        end
        chk({req, " total cycles"}, n, tot);
        chk({req, " wait cycles"}, first, wt);
        chk({req, " sample cycles"}, sh, smp);
        chk({req, " R5 strobes"}, bs, 10);
    endtask

    task automatic watch_quiet(input string req, input int cycles);
        int hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sample_hold || bit_strobe || eoc) hits++;
        end
        chk(req, hits, 0);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R13 outputs", {sample_hold, bit_strobe, eoc, cfg_err}, 0);
        chk("R13 readback", {rd_div_sel, rd_short_smp, rd_trig_mode, rd_enable, rd_start}, 0);
    endtask

    task automatic t_sw_std32();
        do_reset();
        wr(0, 0, 0, 1, 0);
        wr(0, 0, 0, 1, 1);
        measure("R2 R6 div32", 608, 0, 224);
        @(negedge clk);
        chk("R6 start self-clears", rd_start, 0);
        chk("R5 eoc one cycle", eoc, 0);
        chk("R6 no error", cfg_err, 0);
    endtask

    task automatic t_ratios();
        do_reset();
        wr(3, 1, 0, 1, 0);
        wr(3, 1, 0, 1, 1);
        measure("R1 R3 div6 short", 102, 0, 30);
        do_reset();
        wr(4, 0, 0, 1, 0);
        wr(4, 0, 0, 1, 1);
        measure("R1 R2 div5", 95, 0, 35);
        do_reset();
        wr(6, 1, 0, 1, 0);
        wr(6, 1, 0, 1, 1);
        measure("R1 R3 div2 short", 34, 0, 10);
        do_reset();
        wr(1, 0, 0, 1, 0);
        wr(1, 0, 0, 1, 1);
        measure("R1 div16", 304, 0, 112);
        do_reset();
        wr(2, 1, 0, 1, 0);
        wr(2, 1, 0, 1, 1);
        measure("R1 div8 short", 136, 0, 40);
    endtask

    task automatic t_hw_wait();
        do_reset();
        wr(0, 0, 2, 1, 0);
        wr(0, 0, 2, 1, 1);
        watch_quiet("R12 no launch without trigger", 40);
        trig_pulse();
        measure("R4 hw wait div32", 672, 64, 224);
        @(negedge clk);
        chk("R12 start kept in hw mode", rd_start, 1);
    endtask

    task automatic t_hw_busy();
        do_reset();
        wr(5, 1, 1, 1, 0);
        trig_pulse();
        watch_quiet("R12 trigger ignored with start 0", 100);
        wr(5, 1, 1, 1, 1);
        trig_pulse();
        fork
            measure("R4 R12 hw div4 busy trigger", 68, 0, 20);
            begin
                repeat (20) @(negedge clk);
                trig_pulse();
            end
        join
        watch_quiet("R12 no second conversion", 100);
    endtask

    task automatic t_lock();
        do_reset();
        wr(0, 0, 0, 1, 0);
        wr(0, 0, 0, 1, 0);
        @(negedge clk);
        chk("R7 same config accepted", cfg_err, 0);
        wr(6, 1, 0, 1, 0);
        @(negedge clk);
        chk("R7 locked change flagged", cfg_err, 1);
        chk("R7 select unchanged", rd_div_sel, 0);
        chk("R7 speed unchanged", rd_short_smp, 0);
        wr(0, 0, 0, 0, 0);
        wr(6, 1, 0, 1, 0);
        @(negedge clk);
        chk("R10 legal write after error", {rd_div_sel, rd_short_smp, rd_enable}, {3'd6, 1'b1, 1'b1});
        chk("R10 error sticky", cfg_err, 1);
    endtask

    task automatic t_bad_writes();
        do_reset();
        wr(0, 0, 0, 0, 1);
        @(negedge clk);
        chk("R8 start without enable flagged", cfg_err, 1);
        chk("R8 start stays 0", {rd_enable, rd_start}, 0);
        watch_quiet("R8 no conversion", 50);
        do_reset();
        wr(0, 0, 0, 1, 1);
        @(negedge clk);
        chk("R9 joint rise flagged", cfg_err, 1);
        chk("R9 bits unchanged", {rd_enable, rd_start}, 0);
        watch_quiet("R9 no conversion", 50);
        do_reset();
        wr(7, 1, 0, 1, 0);
        @(negedge clk);
        chk("R1 select 7 flagged", cfg_err, 1);
        chk("R10 select 7 ignored", {rd_div_sel, rd_short_smp, rd_enable}, 0);
        do_reset();
        wr(0, 0, 3, 1, 0);
        @(negedge clk);
        chk("R4 mode 3 flagged", cfg_err, 1);
        chk("R10 mode 3 ignored", {rd_trig_mode, rd_enable}, 0);
    endtask

    task automatic t_abort();
        do_reset();
        wr(2, 0, 0, 1, 0);
        wr(2, 0, 0, 1, 1);
        repeat (30) @(negedge clk);
        wr(2, 0, 0, 1, 1);
        @(negedge clk);
        chk("R7 rewrite while running", cfg_err, 0);
        wr(2, 0, 0, 1, 0);
        @(negedge clk);
        chk("R11 outputs drop", {sample_hold, bit_strobe, eoc}, 0);
        chk("R11 start cleared", rd_start, 0);
        watch_quiet("R11 no eoc after abort", 200);
        wr(2, 0, 0, 1, 1);
        measure("R6 relaunch after abort", 152, 0, 56);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sw_std32();
        t_ratios();
        t_hw_wait();
        t_hw_busy();
        t_lock();
        t_bad_writes();
        t_abort();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule